// File: doc/BRIEF.md
# Fetch Patch and Breakpoint Comparator Unit

This unit sits beside an instruction fetch path and compares each fetch address against a bank of programmable comparators. On a hit, it does one of two things. It can steer the fetch to a word in a patch table placed anywhere in the low 512 MB. It can also leave the address alone and overwrite one or both halfwords of the returned word with a 16-bit breakpoint opcode. Six comparators serve code fetches. Two serve literal (data) fetches, and those two can only redirect.

Software programs the unit through a small word-addressed register port. Writes are synchronous and reads are combinational. The fetch side is purely combinational, so the patched address and data follow the fetch inputs in the same cycle. A register write affects fetches from the next clock edge onward.

Register offsets (byte): control 0x00, patch-table base 0x04, comparator n at 0x08 + 4·n for n = 0..7.

Top module: `fetch_patch_unit`

## Requirements
- R1: After synchronous reset every stored field is zero, so the unit is disabled, no fetch hits, and the table base and all comparator registers read 0.
- R2: Control bits [7:4] read 6 (code comparators), bits [11:8] read 2 (literal comparators) and bits [13:12] read 0 (full banks); writes never change them.
- R3: A control write updates the global enable (bit 0) only when written bit 1 is 1; bit 1 always reads 0.
- R4: A comparator can hit only while both the global enable and its own bit 0 are set.
- R5: A comparator holds a word address in bits [28:2]; it hits when fetch bits [28:2] equal it and fetch bits [31:29] are zero, whatever fetch bits [1:0] are.
- R6: Comparator bits [31:30] pick the action: 0 redirect, 1 put 0xBE00 in data bits [15:0], 2 put 0xBE00 in bits [31:16], 3 put it in both; the untouched halfword and the address pass through.
- R7: On a redirect by comparator n the output address is table base + 4·n + fetch bits [1:0], where the base is stored in bits [28:5], and the data passes through.
- R8: Comparators 6 and 7 match only literal fetches and always redirect, whatever action is programmed.
- R9: Comparators 0 to 5 match only code fetches (fetch_is_lit = 0).
- R10: When several comparators hit, the lowest-numbered one decides the result.
- R11: Without a hit, hit is 0, the output address equals the fetch address and the output data equals the fetch data.
- R12: Comparator registers read back only bits [31:30], [28:2] and [0]; the base register reads back only bits [28:5]; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_is_lit | input | 1 | 1 for literal fetch, 0 for code fetch |
| fetch_rdata | input | 32 | Word returned for the fetch |
| out_addr | output | 32 | Address after redirection |
| out_data | output | 32 | Data after breakpoint substitution |
| hit | output | 1 | A comparator matched this fetch |

## Verification
Matching is exercised with code and literal fetches at programmed addresses, at the same word with a non-zero byte offset, and with the upper three address bits set. The address-only miss, the wrong fetch type miss and the disabled miss each isolate a separate qualifying term. All four action codes are applied to one fixed data word, 0x12345678, so that an exchanged halfword shows up in the result. Overlapping comparators are used to show which index wins: two code comparators with different breakpoint actions, and both literal comparators, whose redirect targets differ. A literal comparator programmed with a breakpoint action shows that the data stays unchanged and the fetch is redirected.

// File: rtl/fpu_pkg.sv
package fpu_pkg;

    localparam int DEF_N_CODE = 6;
    localparam int DEF_N_LIT  = 2;
    localparam int REG_AW     = 6;
    localparam int WORD_W     = 32;
    localparam int CMP_AW     = 27;   // compare address bits [28:2]
    localparam int BASE_W     = 24;   // table base bits [28:5]
    localparam logic [15:0] BKPT_OPCODE = 16'hBE00;

    typedef enum logic [1:0] {
        ACT_REDIRECT = 2'd0,
        ACT_BK_LOW   = 2'd1,
        ACT_BK_HIGH  = 2'd2,
        ACT_BK_BOTH  = 2'd3
    } act_e;

    typedef struct packed {
        act_e              act;
        logic [CMP_AW-1:0] waddr;
        logic              en;
    } cmp_cfg_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(cmp_cfg_t c);
        return {c.act, 1'b0, c.waddr, 1'b0, c.en};
    endfunction

    function automatic logic [15:0] pick_half(logic sub, logic [15:0] orig);
        return sub ? BKPT_OPCODE : orig;
    endfunction

endpackage

// File: rtl/fpu_regs.sv
module fpu_regs
    import fpu_pkg::*;
#(
    parameter int N_CODE = DEF_N_CODE,
    parameter int N_LIT  = DEF_N_LIT,
    localparam int N_CMP = N_CODE + N_LIT,
    localparam int WI_W  = REG_AW - 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       addr,
    input  logic [WORD_W-1:0]       wdata,
    output logic [WORD_W-1:0]       rdata,
    output logic                    glob_en,
    output logic [BASE_W-1:0]       tbl_base,
    output cmp_cfg_t [N_CMP-1:0]    cfg
);

    logic [WI_W-1:0] widx;
    assign widx = addr[REG_AW-1:2];

    logic unused_bits;
    assign unused_bits = ^{addr[1:0], wdata[29]};

    // control: global enable guarded by the key bit
    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
        end else if (wr_en && widx == '0 && wdata[1]) begin
            glob_en <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_base <= '0;
        end else if (wr_en && widx == WI_W'(1)) begin
            tbl_base <= wdata[28:5];
        end
    end

    for (genvar k = 0; k < N_CMP; k++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[k] <= '0;
            end else if (wr_en && widx == WI_W'(k + 2)) begin
                cfg[k].act   <= act_e'(wdata[31:30]);
                cfg[k].waddr <= wdata[28:2];
                cfg[k].en    <= wdata[0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (widx == '0) begin
            rdata = {18'b0, 2'b00, 4'(N_LIT), 4'(N_CODE), 2'b00, 1'b0, glob_en};
        end else if (widx == WI_W'(1)) begin
            rdata = {3'b0, tbl_base, 5'b0};
        end else begin
            for (int k = 0; k < N_CMP; k++) begin
                if (widx == WI_W'(k + 2)) begin
                    rdata = cfg_to_word(cfg[k]);
                end
            end
        end
    end

endmodule

// File: rtl/fpu_match.sv
module fpu_match
    import fpu_pkg::*;
#(
    parameter int N_CODE = DEF_N_CODE,
    parameter int N_LIT  = DEF_N_LIT,
    localparam int N_CMP = N_CODE + N_LIT,
    localparam int IDX_W = $clog2(N_CMP)
) (
    input  logic                 glob_en,
    input  cmp_cfg_t [N_CMP-1:0] cfg,
    input  logic [WORD_W-1:2]    fetch_waddr,
    input  logic                 fetch_is_lit,
    output logic                 any_hit,
    output logic [IDX_W-1:0]     win_idx,
    output act_e                 win_act
);

    logic [N_CMP-1:0] hv;
    logic             in_region;

    assign in_region = (fetch_waddr[31:29] == 3'b000);

    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
        localparam bit IS_LIT = (k >= N_CODE);
        assign hv[k] = glob_en && cfg[k].en && in_region
                    && (fetch_waddr[28:2] == cfg[k].waddr)
                    && (fetch_is_lit == IS_LIT);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        any_hit = |hv;
        win_idx = '0;
        win_act = ACT_REDIRECT;
        for (int k = N_CMP - 1; k >= 0; k--) begin
            if (hv[k]) begin
                win_idx = IDX_W'(k);
                win_act = (k >= N_CODE) ? ACT_REDIRECT : cfg[k].act;
            end
        end
    end

endmodule

// File: rtl/fpu_patch.sv
module fpu_patch
    import fpu_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              any_hit,
    input  logic [IDX_W-1:0]  win_idx,
    input  act_e              win_act,
    input  logic [BASE_W-1:0] tbl_base,
    input  logic [WORD_W-1:0] fetch_addr,
    input  logic [WORD_W-1:0] fetch_rdata,
    output logic [WORD_W-1:0] out_addr,
    output logic [WORD_W-1:0] out_data
);

    logic [WORD_W-1:0] redir_addr;
    logic              sub_lo;
    logic              sub_hi;

    assign redir_addr = {3'b0, tbl_base, 5'b0}
                      + (WORD_W'(win_idx) << 2)
                      + {30'b0, fetch_addr[1:0]};

    assign sub_lo = any_hit && (win_act == ACT_BK_LOW  || win_act == ACT_BK_BOTH);
    assign sub_hi = any_hit && (win_act == ACT_BK_HIGH || win_act == ACT_BK_BOTH);

    always_comb begin
        out_addr = fetch_addr;
        if (any_hit && win_act == ACT_REDIRECT) begin
            out_addr = redir_addr;
        end
        out_data = {pick_half(sub_hi, fetch_rdata[31:16]),
                    pick_half(sub_lo, fetch_rdata[15:0])};
    end

endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
    import fpu_pkg::*;
#(
    parameter int N_CODE = DEF_N_CODE,
    parameter int N_LIT  = DEF_N_LIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       fetch_addr,
    input  logic              fetch_is_lit,
    input  logic [31:0]       fetch_rdata,
    output logic [31:0]       out_addr,
    output logic [31:0]       out_data,
    output logic              hit
);

    localparam int N_CMP = N_CODE + N_LIT;
    localparam int IDX_W = $clog2(N_CMP);

    logic                 glob_en;
    logic [BASE_W-1:0]    tbl_base;
    cmp_cfg_t [N_CMP-1:0] cfg;
    logic [IDX_W-1:0]     win_idx;
    act_e                 win_act;

    fpu_regs #(.N_CODE(N_CODE), .N_LIT(N_LIT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .glob_en  (glob_en),
        .tbl_base (tbl_base),
        .cfg      (cfg)
    );

    fpu_match #(.N_CODE(N_CODE), .N_LIT(N_LIT)) u_match (
        .glob_en      (glob_en),
        .cfg          (cfg),
        .fetch_waddr  (fetch_addr[31:2]),
        .fetch_is_lit (fetch_is_lit),
        .any_hit      (hit),
        .win_idx      (win_idx),
        .win_act      (win_act)
    );

    fpu_patch #(.IDX_W(IDX_W)) u_patch (
        .any_hit     (hit),
        .win_idx     (win_idx),
        .win_act     (win_act),
        .tbl_base    (tbl_base),
        .fetch_addr  (fetch_addr),
        .fetch_rdata (fetch_rdata),
        .out_addr    (out_addr),
        .out_data    (out_data)
    );

endmodule

// File: rtl/fpu_checker.sv
module fpu_checker #(
    parameter int N_CODE = 6,
    parameter int N_LIT  = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic [5:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [31:0] fetch_addr,
    input logic        fetch_is_lit,
    input logic [31:0] fetch_rdata,
    input logic [31:0] out_addr,
    input logic [31:0] out_data,
    input logic        hit,
    input logic        glob_en
);

    localparam logic [9:0] ID_FIELDS = {2'b00, 4'(N_LIT), 4'(N_CODE)};

    logic ctrl_sel;
    assign ctrl_sel = (reg_addr[5:2] == 4'd0);

    logic unused_chk;
    assign unused_chk = ^{reg_addr[1:0], reg_wdata[31:2], reg_wdata[0]};

    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctrl_sel |-> (reg_rdata[1] == 1'b0)); // R3

    AST_ID_FIELDS_FIXED: assert property (@(posedge clk) disable iff (rst)
        ctrl_sel |-> (reg_rdata[13:4] == ID_FIELDS)); // R2

    AST_KEYLESS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && ctrl_sel && !reg_wdata[1]) |=> $stable(glob_en)); // R3

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> !hit); // R4

    AST_REGION_ONLY: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr[31:29] != 3'b000) |-> !hit); // R5

    AST_BKPT_HALF: assert property (@(posedge clk) disable iff (rst)
        (hit && out_data != fetch_rdata) |->
            (out_data[15:0] == 16'hBE00 || out_data[31:16] == 16'hBE00)); // R6

    AST_ONE_SIDE_CHANGES: assert property (@(posedge clk) disable iff (rst)
        hit |-> (out_addr == fetch_addr || out_data == fetch_rdata)); // R7

    AST_LIT_DATA_KEPT: assert property (@(posedge clk) disable iff (rst)
        (hit && fetch_is_lit) |-> (out_data == fetch_rdata)); // R8

    AST_MISS_PASSES: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (out_addr == fetch_addr && out_data == fetch_rdata)); // R11

endmodule

bind fetch_patch_unit fpu_checker #(.N_CODE(N_CODE), .N_LIT(N_LIT)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .fetch_addr   (fetch_addr),
    .fetch_is_lit (fetch_is_lit),
    .fetch_rdata  (fetch_rdata),
    .out_addr     (out_addr),
    .out_data     (out_data),
    .hit          (hit),
    .glob_en      (glob_en)
);

// File: tb/fetch_patch_unit_tb_top.sv
module fetch_patch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [31:0] fetch_addr;
    logic        fetch_is_lit;
    logic [31:0] fetch_rdata;
    logic [31:0] out_addr;
    logic [31:0] out_data;
    logic        hit;

    int n_checks = 0;
    int n_errors = 0;

    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam logic [31:0] DATA = 32'h1234_5678;

    always #5 clk = ~clk;

    fetch_patch_unit dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
        .fetch_is_lit(fetch_is_lit), .fetch_rdata(fetch_rdata),
        .out_addr(out_addr), .out_data(out_data), .hit(hit)
    );

    function automatic logic [31:0] cmp_word(int act, logic [31:0] a, bit en);
        return (32'(act) << 30) | (a & 32'h1FFF_FFFC) | {31'b0, en};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [5:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // drive a fetch and check hit, address and data
    task automatic fetch_check(string tag, logic [31:0] a, bit lit, logic [31:0] d,
                               bit exp_hit, logic [31:0] exp_a, logic [31:0] exp_d);
        fetch_addr = a; fetch_is_lit = lit; fetch_rdata = d;
        #1;
        check({tag, " hit"}, {31'b0, hit}, {31'b0, exp_hit});
        check({tag, " addr"}, out_addr, exp_a);
        check({tag, " data"}, out_data, exp_d);
    endtask

    task automatic t_reset;
        rd_check("R1/R2 ctrl after reset", 6'h00, 32'h0000_0260);
        rd_check("R1 base after reset", 6'h04, 32'h0);
        rd_check("R1 cmp0 after reset", 6'h08, 32'h0);
        rd_check("R1 cmp7 after reset", 6'h24, 32'h0);
        fetch_check("R1 no hit after reset", 32'h0, 1'b0, DATA, 1'b0, 32'h0, DATA);
    endtask

    task automatic t_key;
        wr(6'h00, 32'h0000_3FF1);
        rd_check("R3 keyless write ignored", 6'h00, 32'h0000_0260);
        wr(6'h00, 32'hFFFF_FFFF);
        rd_check("R2/R3 keyed write, key reads 0", 6'h00, 32'h0000_0261);
        wr(6'h00, 32'h0000_0000);
        rd_check("R3 keyless clear ignored", 6'h00, 32'h0000_0261);
    endtask

    task automatic t_readback;
        wr(6'h08, 32'hFFFF_FFFF);
        rd_check("R12 cmp mask", 6'h08, 32'hDFFF_FFFD);
        wr(6'h04, 32'hFFFF_FFFF);
        rd_check("R12 base mask", 6'h04, 32'h1FFF_FFE0);
        wr(6'h08, 32'h0);
        wr(6'h04, BASE);
        rd_check("R12 base value", 6'h04, BASE);
    endtask

    task automatic t_enable;
        wr(6'h08, cmp_word(0, 32'h100, 1'b0));
        fetch_check("R4 cmp disabled", 32'h100, 1'b0, DATA, 1'b0, 32'h100, DATA);
        wr(6'h08, cmp_word(0, 32'h100, 1'b1));
        wr(6'h00, 32'h2);
        fetch_check("R4 global off", 32'h100, 1'b0, DATA, 1'b0, 32'h100, DATA);
        wr(6'h00, 32'h3);
        fetch_check("R4/R7 both on", 32'h100, 1'b0, DATA, 1'b1, BASE, DATA);
        fetch_check("R11 other address", 32'h104, 1'b0, DATA, 1'b0, 32'h104, DATA);
    endtask

    task automatic t_remap;
        wr(6'h10, cmp_word(0, 32'h204, 1'b1));
        fetch_check("R7 cmp2 redirect", 32'h204, 1'b0, DATA, 1'b1, BASE + 32'h8, DATA);
        fetch_check("R5/R7 byte offset", 32'h206, 1'b0, DATA, 1'b1, BASE + 32'hA, DATA);
        fetch_check("R5 upper bits block", 32'h2000_0204, 1'b0, DATA, 1'b0, 32'h2000_0204, DATA);
    endtask

    task automatic t_bkpt;
        wr(6'h0C, cmp_word(1, 32'h300, 1'b1));
        fetch_check("R6 low half", 32'h300, 1'b0, DATA, 1'b1, 32'h300, 32'h1234_BE00);
        wr(6'h0C, cmp_word(2, 32'h300, 1'b1));
        fetch_check("R6 high half", 32'h300, 1'b0, DATA, 1'b1, 32'h300, 32'hBE00_5678);
        wr(6'h0C, cmp_word(3, 32'h300, 1'b1));
        fetch_check("R6 both halves", 32'h300, 1'b0, DATA, 1'b1, 32'h300, 32'hBE00_BE00);
        fetch_check("R9 code cmp ignores literal", 32'h300, 1'b1, DATA, 1'b0, 32'h300, DATA);
    endtask

    task automatic t_literal;
        wr(6'h20, cmp_word(3, 32'h400, 1'b1));
        fetch_check("R8 lit cmp forces redirect", 32'h400, 1'b1, DATA, 1'b1, BASE + 32'h18, DATA);
        fetch_check("R8 lit cmp ignores code", 32'h400, 1'b0, DATA, 1'b0, 32'h400, DATA);
    endtask

    task automatic t_priority;
        wr(6'h14, cmp_word(1, 32'h500, 1'b1));
        wr(6'h18, cmp_word(2, 32'h500, 1'b1));
        fetch_check("R10 cmp3 over cmp4", 32'h500, 1'b0, DATA, 1'b1, 32'h500, 32'h1234_BE00);
        wr(6'h14, cmp_word(1, 32'h500, 1'b0));
        fetch_check("R10 cmp4 alone", 32'h500, 1'b0, DATA, 1'b1, 32'h500, 32'hBE00_5678);
        wr(6'h20, cmp_word(0, 32'h600, 1'b1));
        wr(6'h24, cmp_word(0, 32'h600, 1'b1));
        fetch_check("R10 cmp6 over cmp7", 32'h600, 1'b1, DATA, 1'b1, BASE + 32'h18, DATA);
        wr(6'h20, 32'h0);
        fetch_check("R10 cmp7 alone", 32'h600, 1'b1, DATA, 1'b1, BASE + 32'h1C, DATA);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        fetch_addr = '0; fetch_is_lit = 1'b0; fetch_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_key();
        t_readback();
        t_enable();
        t_remap();
        t_bkpt();
        t_literal();
        t_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule